// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Buffer Router

This block sits after a CAN receiver. When a frame has been fully received, it decides whether the frame is kept and which of two receive buffers takes it. The receiver presents the identifier, the IDE and RTR bits, the DLC and the first two data bytes, then pulses a strobe. The block compares the frame against six programmable filters. The filters are split into two groups, and each group has its own mask.

Buffer 0 owns the low group of filters and buffer 1 owns the rest. Buffer 0 wins when both groups hit. A frame that belongs to a full buffer 0 can move to buffer 1 if rollover is enabled. Otherwise it is dropped and an overflow pulse is raised. For standard data frames, the filter bits that an 11-bit identifier leaves unused are compared against the first two data bytes. This gives a cheap way to filter on payload content.

One cycle after the strobe, the block gives an accept pulse, the chosen buffer, the number of the winning filter and a load pulse for that buffer.

Top module: `can_acc_filter`

## Requirements
- R1: While reset is asserted and after it is released, all outputs are 0 until the first frame strobe.
- R2: A mask bit of 1 requires the frame bit to equal the filter bit, and a mask bit of 0 makes that position don't-care. For an extended frame, all 29 bits of `frm_id_i` are compared with the filter. Bits [28:18] hold the base part and bits [17:0] hold the extended part.
- R3: A filter can hit only when its extended-enable bit in `flt_ext_i` equals the frame's IDE bit.
- R4: For a standard frame, only `frm_id_i[10:0]` is used, and it is compared with filter bits [28:18]. Filter bits [17:16] are always ignored. Filter bits [15:8] are compared with data byte 0 and filter bits [7:0] with data byte 1.
- R5: The data-byte comparison applies only when RTR is 0. Byte 0 is compared only when DLC ≥ 1 and byte 1 only when DLC ≥ 2.
- R6: Filters 0 and 1 use `mask0_i` and feed buffer 0. Filters 2 to 5 use `mask1_i` and feed buffer 1. Filter k sits at `flt_id_i[k*29 +: 29]`. When both groups hit and buffer 0 is free, the frame goes to buffer 0 (`buf_o`=0, `load0_o`=1).
- R7: `hit_o` reports, in binary, the lowest-numbered hitting filter of the group that owns the frame.
- R8: This requirement covers the buffer-full cases.
  - A group-0 hit with buffer 0 full, rollover enabled and buffer 1 free is stored in buffer 1. In that case `buf_o`=1, `load1_o`=1 and `hit_o` holds the group-0 filter.
  - A group-0 hit with buffer 0 full that cannot roll over is discarded with `ovf_o`=1.
  - A group-1 hit with buffer 1 full is discarded with `ovf_o`=1.
- R9: A standard frame while `en_std_i`=0, or an extended frame while `en_ext_i`=0, hits no filter. It gives neither accept nor overflow.
- R10: Results appear on the cycle after the strobe.
  - `acc_o`, `load0_o`, `load1_o` and `ovf_o` are single-cycle pulses.
  - `buf_o` and `hit_o` keep their value until the next strobe.
  - Both `buf_o` and `hit_o` read 0 for a frame that is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| frm_vld_i | input | 1 | One-cycle strobe: frame fields valid |
| frm_id_i | input | 29 | Identifier (standard frames use bits [10:0]) |
| frm_ide_i | input | 1 | 1 = extended frame |
| frm_rtr_i | input | 1 | 1 = remote frame |
| frm_dlc_i | input | 4 | Data length code |
| frm_d0_i | input | 8 | First data byte |
| frm_d1_i | input | 8 | Second data byte |
| mask0_i | input | 29 | Mask for the buffer-0 group |
| mask1_i | input | 29 | Mask for the buffer-1 group |
| flt_id_i | input | 174 | Six packed 29-bit filter values |
| flt_ext_i | input | 6 | Per-filter extended-frame enable |
| en_std_i | input | 1 | Accept standard frames |
| en_ext_i | input | 1 | Accept extended frames |
| roll_en_i | input | 1 | Allow rollover from buffer 0 to buffer 1 |
| full0_i | input | 1 | Buffer 0 full |
| full1_i | input | 1 | Buffer 1 full |
| acc_o | output | 1 | Frame accepted pulse |
| buf_o | output | 1 | Selected buffer |
| hit_o | output | 3 | Winning filter number |
| load0_o | output | 1 | Load pulse for buffer 0 |
| load1_o | output | 1 | Load pulse for buffer 1 |
| ovf_o | output | 1 | Overflow pulse (matched frame dropped) |

## Verification
The embedded assertions check, on every cycle, that the routing is consistent:
- no load pulse goes to a buffer that was full on the strobe cycle;
- a pulse appears only after a strobe;
- overflow excludes accept;
- a buffer-0 load carries a group-0 filter number;
- the buffer and filter outputs hold between strobes.

Whether a given frame should hit at all depends on the bit-level compare. That covers mask don't-cares, the IDE check, payload bytes gated by RTR and DLC, and lowest-index selection. Only the bench scenarios can show these, by comparing against an independent per-bit model under directed and random frames.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
   localparam int CAN_ID_W   = 29;
   localparam int CAN_BASE_W = 11;
   localparam int CAN_BYTE_W = 8;
   localparam int CAN_DLC_W  = 4;

   typedef enum logic [2:0] {
      RT_NONE = 3'd0,
      RT_B0   = 3'd1,
      RT_ROLL = 3'd2,
      RT_B1   = 3'd3,
      RT_OVF  = 3'd4
   } route_e;
endpackage

// File: rtl/can_acc_cmpword.sv
module can_acc_cmpword #(
   parameter int ID_W   = can_acc_pkg::CAN_ID_W,
   parameter int BASE_W = can_acc_pkg::CAN_BASE_W,
   parameter int BYTE_W = can_acc_pkg::CAN_BYTE_W,
   parameter int DLC_W  = can_acc_pkg::CAN_DLC_W
) (
   input  logic [ID_W-1:0]   id_i,
   input  logic              ide_i,
   input  logic              rtr_i,
   input  logic [DLC_W-1:0]  dlc_i,
   input  logic [BYTE_W-1:0] d0_i,
   input  logic [BYTE_W-1:0] d1_i,
   output logic [ID_W-1:0]   cmp_o,
   output logic [ID_W-1:0]   use_o
);
   localparam int PAY_W = 2 * BYTE_W;

   logic use_b0, use_b1;

   assign use_b0 = !rtr_i && (dlc_i >= DLC_W'(1));
   assign use_b1 = !rtr_i && (dlc_i >= DLC_W'(2));

   always_comb begin
      if (ide_i) begin
         cmp_o = id_i;
         use_o = '1;
      end else begin
         cmp_o = '0;
         use_o = '0;
         cmp_o[ID_W-1 -: BASE_W] = id_i[BASE_W-1:0];
         use_o[ID_W-1 -: BASE_W] = '1;
         cmp_o[PAY_W-1 -: BYTE_W] = d0_i;
         use_o[PAY_W-1 -: BYTE_W] = {BYTE_W{use_b0}};
         cmp_o[BYTE_W-1:0] = d1_i;
         use_o[BYTE_W-1:0] = {BYTE_W{use_b1}};
      end
   end

   always_comb begin
      if (!ide_i) begin
         assert (use_o[PAY_W +: (ID_W-BASE_W-PAY_W)] == '0)
            else $error("a_r4_gap_ignored");
      end
   end
endmodule

// File: rtl/can_acc_match.sv
module can_acc_match #(
   parameter int ID_W = can_acc_pkg::CAN_ID_W
) (
   input  logic [ID_W-1:0] cmp_i,
   input  logic [ID_W-1:0] use_i,
   input  logic [ID_W-1:0] mask_i,
   input  logic [ID_W-1:0] filt_i,
   input  logic            fext_i,
   input  logic            ide_i,
   input  logic            type_ok_i,
   output logic            hit_o
);
   logic [ID_W-1:0] diff;

   assign diff  = (cmp_i ^ filt_i) & mask_i & use_i;
   assign hit_o = type_ok_i && (fext_i == ide_i) && (diff == '0);
endmodule

// File: rtl/can_acc_prio.sv
module can_acc_prio #(
   parameter int N    = 2,
   parameter int BASE = 0,
   parameter int HW   = 3
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [HW-1:0] idx_o
);
   assign any_o = |req_i;

   generate
      if (N == 1) begin : g_single
         assign idx_o = HW'(BASE);
      end else begin : g_multi
         always_comb begin
            idx_o = HW'(BASE);
            for (int k = N - 1; k >= 0; k--) begin
               if (req_i[k]) idx_o = HW'(BASE + k);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/can_acc_route.sv
module can_acc_route
   import can_acc_pkg::*;
#(
   parameter int NFLT = 6,
   parameter int NB0  = 2,
   parameter int HW   = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            vld_i,
   input  logic [NFLT-1:0] hit_i,
   input  logic            full0_i,
   input  logic            full1_i,
   input  logic            roll_en_i,
   output logic            acc_o,
   output logic            buf_o,
   output logic [HW-1:0]   hit_o,
   output logic            load0_o,
   output logic            load1_o,
   output logic            ovf_o
);
   localparam int NB1 = NFLT - NB0;

   logic          g0, g1;
   logic [HW-1:0] idx0, idx1;
   route_e        dec;

   can_acc_prio #(.N(NB0), .BASE(0), .HW(HW)) u_prio0 (
      .req_i (hit_i[NB0-1:0]),
      .any_o (g0),
      .idx_o (idx0)
   );

   can_acc_prio #(.N(NB1), .BASE(NB0), .HW(HW)) u_prio1 (
      .req_i (hit_i[NFLT-1:NB0]),
      .any_o (g1),
      .idx_o (idx1)
   );

   always_comb begin
      dec = RT_NONE;
      if (g0) begin
         if (!full0_i)                  dec = RT_B0;
         else if (roll_en_i && !full1_i) dec = RT_ROLL;
         else                           dec = RT_OVF;
      end else if (g1) begin
         dec = full1_i ? RT_OVF : RT_B1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_o   <= 1'b0;
         buf_o   <= 1'b0;
         hit_o   <= '0;
         load0_o <= 1'b0;
         load1_o <= 1'b0;
         ovf_o   <= 1'b0;
      end else if (vld_i) begin
         acc_o   <= (dec == RT_B0) || (dec == RT_ROLL) || (dec == RT_B1);
         load0_o <= (dec == RT_B0);
         load1_o <= (dec == RT_ROLL) || (dec == RT_B1);
         ovf_o   <= (dec == RT_OVF);
         buf_o   <= (dec == RT_ROLL) || (dec == RT_B1);
         case (dec)
            RT_B0, RT_ROLL: hit_o <= idx0;
            RT_B1:          hit_o <= idx1;
            default:        hit_o <= '0;
         endcase
      end else begin
         acc_o   <= 1'b0;
         load0_o <= 1'b0;
         load1_o <= 1'b0;
         ovf_o   <= 1'b0;
      end
   end

   a_r8_no_load_full0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load0_o |-> !$past(full0_i));
   a_r8_no_load_full1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load1_o |-> !$past(full1_i));
   a_r10_pulse_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_o || ovf_o) |-> $past(vld_i));
   a_r8_ovf_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> (!acc_o && !load0_o && !load1_o));
   a_r6_b0_group_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load0_o |-> (hit_o < HW'(NB0)));
   a_r10_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(vld_i) |-> ($stable(buf_o) && $stable(hit_o)));
   a_r10_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({load0_o, load1_o}));
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
   import can_acc_pkg::*;
#(
   parameter int NFLT   = 6,
   parameter int NB0    = 2,
   parameter int ID_W   = CAN_ID_W,
   parameter int BASE_W = CAN_BASE_W,
   parameter int BYTE_W = CAN_BYTE_W,
   parameter int DLC_W  = CAN_DLC_W,
   parameter int HW     = $clog2(NFLT)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 frm_vld_i,
   input  logic [ID_W-1:0]      frm_id_i,
   input  logic                 frm_ide_i,
   input  logic                 frm_rtr_i,
   input  logic [DLC_W-1:0]     frm_dlc_i,
   input  logic [BYTE_W-1:0]    frm_d0_i,
   input  logic [BYTE_W-1:0]    frm_d1_i,
   input  logic [ID_W-1:0]      mask0_i,
   input  logic [ID_W-1:0]      mask1_i,
   input  logic [NFLT*ID_W-1:0] flt_id_i,
   input  logic [NFLT-1:0]      flt_ext_i,
   input  logic                 en_std_i,
   input  logic                 en_ext_i,
   input  logic                 roll_en_i,
   input  logic                 full0_i,
   input  logic                 full1_i,
   output logic                 acc_o,
   output logic                 buf_o,
   output logic [HW-1:0]        hit_o,
   output logic                 load0_o,
   output logic                 load1_o,
   output logic                 ovf_o
);
   generate
      if (NB0 < 1 || NB0 >= NFLT) begin : g_bad_split
         $error("can_acc_filter: NB0 must leave both groups non-empty");
      end
      if (ID_W < BASE_W + 2 * BYTE_W + 1) begin : g_bad_width
         $error("can_acc_filter: identifier too narrow for payload compare");
      end
      if ((1 << HW) < NFLT) begin : g_bad_hw
         $error("can_acc_filter: HW too small for filter count");
      end
   endgenerate

   logic [ID_W-1:0] cmp_w, use_w;
   logic [NFLT-1:0] hit_w;
   logic            type_ok;

   assign type_ok = frm_ide_i ? en_ext_i : en_std_i;

   can_acc_cmpword #(
      .ID_W(ID_W), .BASE_W(BASE_W), .BYTE_W(BYTE_W), .DLC_W(DLC_W)
   ) u_cmp (
      .id_i  (frm_id_i),
      .ide_i (frm_ide_i),
      .rtr_i (frm_rtr_i),
      .dlc_i (frm_dlc_i),
      .d0_i  (frm_d0_i),
      .d1_i  (frm_d1_i),
      .cmp_o (cmp_w),
      .use_o (use_w)
   );

   for (genvar i = 0; i < NFLT; i++) begin : g_flt
      logic [ID_W-1:0] msk;
      if (i < NB0) begin : g_grp0
         assign msk = mask0_i;
      end else begin : g_grp1
         assign msk = mask1_i;
      end
      can_acc_match #(.ID_W(ID_W)) u_match (
         .cmp_i     (cmp_w),
         .use_i     (use_w),
         .mask_i    (msk),
         .filt_i    (flt_id_i[i*ID_W +: ID_W]),
         .fext_i    (flt_ext_i[i]),
         .ide_i     (frm_ide_i),
         .type_ok_i (type_ok),
         .hit_o     (hit_w[i])
      );
   end

   can_acc_route #(.NFLT(NFLT), .NB0(NB0), .HW(HW)) u_route (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .vld_i     (frm_vld_i),
      .hit_i     (hit_w),
      .full0_i   (full0_i),
      .full1_i   (full1_i),
      .roll_en_i (roll_en_i),
      .acc_o     (acc_o),
      .buf_o     (buf_o),
      .hit_o     (hit_o),
      .load0_o   (load0_o),
      .load1_o   (load1_o),
      .ovf_o     (ovf_o)
   );

   a_r9_disabled_type_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld_i && !type_ok) |=> (!acc_o && !ovf_o));
   a_r3_ide_agrees: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld_i && (hit_w == '0)) |=> (!acc_o && !ovf_o));
endmodule

// File: tb/tb_can_acc_filter.sv
module tb_can_acc_filter;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         vld;
   logic [28:0]  fid;
   logic         ide, rtr;
   logic [3:0]   dlc;
   logic [7:0]   d0, d1;
   logic [28:0]  m0, m1;
   logic [173:0] flt;
   logic [5:0]   fext;
   logic         en_std, en_ext, roll, f0, f1;
   logic         acc, bsel, ld0, ld1, ovf;
   logic [2:0]   hit;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   can_acc_filter dut (
      .clk_i(clk), .rst_ni(rst_n), .frm_vld_i(vld), .frm_id_i(fid),
      .frm_ide_i(ide), .frm_rtr_i(rtr), .frm_dlc_i(dlc), .frm_d0_i(d0),
      .frm_d1_i(d1), .mask0_i(m0), .mask1_i(m1), .flt_id_i(flt),
      .flt_ext_i(fext), .en_std_i(en_std), .en_ext_i(en_ext),
      .roll_en_i(roll), .full0_i(f0), .full1_i(f1), .acc_o(acc),
      .buf_o(bsel), .hit_o(hit), .load0_o(ld0), .load1_o(ld1), .ovf_o(ovf)
   );

   function automatic logic [7:0] outs();
      return {acc, bsel, hit, ld0, ld1, ovf};
   endfunction

   // independent per-bit model of one filter
   function automatic bit filt_hit(int k);
      logic [28:0] f;
      logic [28:0] m;
      bit fb, use_b;
      f = flt[k*29 +: 29];
      m = (k < 2) ? m0 : m1;
      if ((ide ? en_ext : en_std) == 1'b0) return 0;
      if (fext[k] != ide) return 0;
      for (int b = 0; b < 29; b++) begin
         fb = 0; use_b = 0;
         if (ide) begin fb = fid[b]; use_b = 1; end
         else if (b >= 18) begin fb = fid[b-18]; use_b = 1; end
         else if (b >= 16) use_b = 0;
         else if (b >= 8) begin fb = d0[b-8]; use_b = !rtr && (dlc >= 1); end
         else begin fb = d1[b]; use_b = !rtr && (dlc >= 2); end
         if (use_b && m[b] && (fb != f[b])) return 0;
      end
      return 1;
   endfunction

   function automatic logic [7:0] model();
      int lo0, lo1;
      lo0 = -1; lo1 = -1;
      for (int k = 5; k >= 0; k--) begin
         if (filt_hit(k)) begin
            if (k < 2) lo0 = k; else lo1 = k;
         end
      end
      if (lo0 >= 0) begin
         if (!f0) return {1'b1, 1'b0, 3'(lo0), 3'b100};
         if (roll && !f1) return {1'b1, 1'b1, 3'(lo0), 3'b010};
         return 8'h01;
      end
      if (lo1 >= 0) begin
         if (!f1) return {1'b1, 1'b1, 3'(lo1), 3'b010};
         return 8'h01;
      end
      return 8'h00;
   endfunction

   task automatic check(string tag, logic [7:0] exp);
      total++;
      if (outs() !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, outs(), exp);
      end
   endtask

   task automatic send();
      @(negedge clk);
      vld = 1'b1;
      @(negedge clk);
      vld = 1'b0;
   endtask

   task automatic base_cfg();
      m0 = '1; m1 = '1;
      flt = '1; fext = '0;
      en_std = 1; en_ext = 1; roll = 0; f0 = 0; f1 = 0;
      ide = 1; rtr = 0; dlc = 4'd8; d0 = 0; d1 = 0;
      fid = 29'h1234567;
   endtask

   task automatic std_cfg(int k);
      base_cfg();
      ide = 0; fid = 29'h0ABCD5A3; rtr = 0; dlc = 4'd2; d0 = 8'hC3; d1 = 8'h3C;
      flt[k*29 +: 29] = {11'h5A3, 2'b11, 8'hC3, 8'h3C};
      fext[k] = 0;
   endtask

   initial begin
      void'($urandom(32'd20240607));
      rst_n = 0; vld = 0;
      base_cfg();
      repeat (3) @(negedge clk);
      check("R1 in reset", 8'h00);
      rst_n = 1;
      @(negedge clk);
      check("R1 after reset", 8'h00);

      // R2 exact extended match
      base_cfg(); flt[0 +: 29] = 29'h1234567; fext[0] = 1;
      send(); check("R2 exact ext", 8'h84);
      // R10 pulses drop, buffer/filter hold
      @(negedge clk); check("R10 pulse clears", 8'h00);
      // R3 ext bit mismatch
      base_cfg(); flt[0 +: 29] = 29'h1234567; fext[0] = 0;
      send(); check("R3 ide mismatch", 8'h00);
      // R2 don't-care bits
      base_cfg(); flt[0 +: 29] = 29'h1234560; fext[0] = 1; m0 = ~29'hF;
      send(); check("R2 mask dontcare", 8'h84);
      base_cfg(); flt[0 +: 29] = 29'h1234560; fext[0] = 1;
      send(); check("R2 mask compares", 8'h00);
      // R7 lowest index
      base_cfg(); flt[29 +: 29] = 29'h1234567; fext[1] = 1;
      flt[0 +: 29] = 29'h1234567; fext[0] = 1;
      send(); check("R7 both b0 filters", 8'h84);
      base_cfg(); flt[58 +: 29] = 29'h1234567; flt[87 +: 29] = 29'h1234567;
      fext[2] = 1; fext[3] = 1;
      send(); check("R7 group1 lowest", 8'hD2);
      // R6 buffer 0 priority
      base_cfg(); flt[29 +: 29] = 29'h1234567; flt[87 +: 29] = 29'h1234567;
      fext[1] = 1; fext[3] = 1;
      send(); check("R6 b0 priority", 8'h8C);
      // R4 standard payload compare
      std_cfg(4); send(); check("R4 std payload hit", 8'hE2);
      std_cfg(4); d1 = 8'h3D; send(); check("R4 byte1 mismatch", 8'h00);
      std_cfg(4); d0 = 8'h00; send(); check("R4 byte0 mismatch", 8'h00);
      // R5 DLC and RTR gating
      std_cfg(4); dlc = 4'd1; d1 = 8'h3D; send(); check("R5 dlc1 skips byte1", 8'hE2);
      std_cfg(4); dlc = 4'd0; d0 = 8'h11; d1 = 8'h22; send(); check("R5 dlc0 skips bytes", 8'hE2);
      std_cfg(4); rtr = 1; d0 = 8'h00; d1 = 8'h00; send(); check("R5 remote skips bytes", 8'hE2);
      // R9 type enables
      std_cfg(4); en_std = 0; send(); check("R9 std disabled", 8'h00);
      base_cfg(); flt[0 +: 29] = 29'h1234567; fext[0] = 1; en_ext = 0;
      send(); check("R9 ext disabled", 8'h00);
      // R8 full handling
      base_cfg(); flt[0 +: 29] = 29'h1234567; fext[0] = 1; f0 = 1; roll = 1;
      send(); check("R8 rollover", 8'hC2);
      @(negedge clk); check("R10 hold after rollover", 8'h40);
      base_cfg(); flt[0 +: 29] = 29'h1234567; fext[0] = 1; f0 = 1; roll = 0;
      send(); check("R8 full no rollover", 8'h01);
      base_cfg(); flt[0 +: 29] = 29'h1234567; fext[0] = 1; f0 = 1; roll = 1; f1 = 1;
      send(); check("R8 both full", 8'h01);
      base_cfg(); flt[58 +: 29] = 29'h1234567; fext[2] = 1; f1 = 1;
      send(); check("R8 b1 full", 8'h01);

      // random frames against the model
      for (int n = 0; n < 600; n++) begin
         logic [28:0] derived;
         @(negedge clk);
         ide = 1'($urandom); rtr = 1'($urandom); dlc = 4'($urandom % 11);
         fid = 29'($urandom); d0 = 8'($urandom); d1 = 8'($urandom);
         derived = ide ? fid : {fid[10:0], 2'($urandom), d0, d1};
         m0 = 29'($urandom) | 29'($urandom);
         m1 = 29'($urandom) | 29'($urandom);
         for (int k = 0; k < 6; k++) begin
            if ($urandom % 3 != 0)
               flt[k*29 +: 29] = derived ^ (29'($urandom) & 29'($urandom) & 29'($urandom)
                                            & 29'($urandom) & {29{1'($urandom)}});
            else
               flt[k*29 +: 29] = 29'($urandom);
            fext[k] = ($urandom % 5 == 0) ? ~ide : ide;
         end
         en_std = ($urandom % 8 != 0); en_ext = ($urandom % 8 != 0);
         roll = 1'($urandom); f0 = ($urandom % 3 == 0); f1 = ($urandom % 3 == 0);
         vld = 1'b1;
         @(negedge clk);
         vld = 1'b0;
         check("R6 R7 R8 random", model());
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule